// File: doc/BRIEF.md
# Input Virtual Channel Controller

This block sits at one input of a virtual-channel router and keeps the routing state of each packet that is passing through each input virtual channel. For every input VC it holds three fields: the output port the packet is bound for, a lock flag that shows an output VC is held, and the id of that output VC. Each cycle it looks at the flit at the front of each VC buffer and decides what that flit asks for. It asks either for an output VC from the VC allocator or for a crossbar slot from the switch allocator.

A head flit whose VC holds no lock asks for an output VC. It uses the route supplied by the route computation logic. When the VC allocator grants, the lock is taken and the granted id is stored. The same flit also asks the switch allocator in that same cycle. Later flits of the packet reuse the stored port and output VC and go straight to switch allocation. A flit leaves its buffer in the cycle its switch request is granted. When a tail flit leaves, all three fields are cleared, so the head of the next packet can start allocation in the very next cycle. Route computation and the flit buffers themselves sit outside this block.

Top module: `ivc_ctrl`

## Requirements
- R1: While reset is held and right after it is released, every VC is unlocked. A body flit at the front then raises no request, and a head flit raises a VC request.
- R2: A valid head flit (type 01 or 11) in an unlocked VC raises its VC request, and its requested port equals the route at the buffer head. It raises no switch request unless a VC grant arrives in the same cycle.
- R3: In the cycle a VC request is granted, the same VC raises a switch request. That request carries the route at the buffer head as its port and the granted output VC id as its VC.
- R4: A locked VC raises no VC request. It raises a switch request whenever its front flit is valid, and no request when the front is empty.
- R5: Body (00) and tail (10) flits in a locked VC present the stored port and output VC. The route value at the buffer head has no effect on them.
- R6: The dequeue strobe of a VC is high exactly when that VC requests the switch and is granted it.
- R7: When a tail flit is dequeued, the VC is unlocked in the next cycle. A head flit arriving then raises its VC request in that cycle with no idle cycle.
- R8: A single-flit packet (type 11) that is granted a VC and the switch in the same cycle leaves the VC unlocked in the next cycle.
- R9: A body or tail flit in an unlocked VC raises no request and is never dequeued.
- R10: A VC grant without a matching VC request is ignored: the VC stays unlocked.
- R11: Each VC's state and requests depend only on its own inputs.
- R12: Dequeuing a head or body flit keeps the lock, port and output VC for the next flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_vld | input | NUM_VC | Front of each VC buffer holds a flit |
| flit_type | input | 2*NUM_VC | Flit type per VC: bit 0 head, bit 1 tail |
| flit_route | input | PW*NUM_VC | Output port computed for the front flit |
| va_gnt | input | NUM_VC | VC allocator grant per input VC |
| va_gnt_ovc | input | OW*NUM_VC | Granted output VC id per input VC |
| sa_gnt | input | NUM_VC | Switch allocator grant per input VC |
| va_req | output | NUM_VC | VC allocation request per input VC |
| va_port | output | PW*NUM_VC | Output port for the VC request |
| sa_req | output | NUM_VC | Switch allocation request per input VC |
| sa_port | output | PW*NUM_VC | Output port for the switch request |
| sa_ovc | output | OW*NUM_VC | Output VC id carried with the switch request |
| deq | output | NUM_VC | Dequeue strobe to each VC buffer |

## Verification
The hardest case to reach is two events on one VC in the same edge. In one, a tail departs and the next head must start allocation one cycle later. In the other, a single-flit packet takes a lock and drops it in the same cycle. The stimulus table reaches both by driving the tail with its switch grant and placing the next head in the following row. It also drives a head-and-tail flit with both grants at once. The following rows then check that the VC requests allocation again instead of the switch. Grants with no request and flits that arrive in an unlocked VC without a head are mixed into the same stream, so any stray lock shows up as a wrong request later on.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

  typedef enum logic [1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10,
    FT_SOLO = 2'b11
  } flit_kind_e;

  function automatic logic kind_is_head(input logic [1:0] kind);
    return kind[0];
  endfunction

  function automatic logic kind_is_tail(input logic [1:0] kind);
    return kind[1];
  endfunction

endpackage

// File: rtl/ivc_vc_state.sv
module ivc_vc_state #(
  parameter int PW = 3,
  parameter int OW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [PW-1:0] set_port,
  input  logic [OW-1:0] set_ovc,
  input  logic          clr_en,
  output logic          lock_q,
  output logic [PW-1:0] port_q,
  output logic [OW-1:0] ovc_q
);

  logic          upd_en;
  logic          lock_d;
  logic [PW-1:0] port_d;
  logic [OW-1:0] ovc_d;

  // Clearing wins: a single-flit packet takes and drops the lock together.
  always_comb begin
    upd_en = set_en | clr_en;
    lock_d = lock_q;
    port_d = port_q;
    ovc_d  = ovc_q;
    if (clr_en) begin
      lock_d = 1'b0;
      port_d = '0;
      ovc_d  = '0;
    end else if (set_en) begin
      lock_d = 1'b1;
      port_d = set_port;
      ovc_d  = set_ovc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      port_q <= '0;
      ovc_q  <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      port_q <= port_d;
      ovc_q  <= ovc_d;
    end
  end

endmodule

// File: rtl/ivc_vc_req.sv
module ivc_vc_req
  import ivc_pkg::*;
#(
  parameter int PW = 3,
  parameter int OW = 2
) (
  input  logic          flit_vld,
  input  logic [1:0]    flit_type,
  input  logic [PW-1:0] flit_route,
  input  logic          lock_q,
  input  logic [PW-1:0] port_q,
  input  logic [OW-1:0] ovc_q,
  input  logic          va_gnt,
  input  logic [OW-1:0] va_gnt_ovc,
  input  logic          sa_gnt,
  output logic          va_req,
  output logic [PW-1:0] va_port,
  output logic          sa_req,
  output logic [PW-1:0] sa_port,
  output logic [OW-1:0] sa_ovc,
  output logic          deq,
  output logic          set_en,
  output logic [PW-1:0] set_port,
  output logic [OW-1:0] set_ovc,
  output logic          clr_en
);

  logic is_hd;
  logic is_tl;
  logic va_win;

  always_comb begin
    is_hd    = kind_is_head(flit_type);
    is_tl    = kind_is_tail(flit_type);
    va_req   = flit_vld & is_hd & ~lock_q;
    va_port  = flit_route;
    va_win   = va_req & va_gnt;
    // A fresh grant is bypassed straight into the switch request.
    sa_req   = flit_vld & (lock_q | va_win);
    sa_port  = lock_q ? port_q : flit_route;
    sa_ovc   = lock_q ? ovc_q  : va_gnt_ovc;
    deq      = sa_req & sa_gnt;
    set_en   = va_win;
    set_port = flit_route;
    set_ovc  = va_gnt_ovc;
    clr_en   = deq & is_tl;
  end

endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl #(
  parameter int NUM_VC   = 4,
  parameter int NUM_PORT = 5,
  parameter int NUM_OVC  = 4,
  localparam int PW = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1,
  localparam int OW = (NUM_OVC  > 1) ? $clog2(NUM_OVC)  : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_VC-1:0]    flit_vld,
  input  logic [2*NUM_VC-1:0]  flit_type,
  input  logic [PW*NUM_VC-1:0] flit_route,
  input  logic [NUM_VC-1:0]    va_gnt,
  input  logic [OW*NUM_VC-1:0] va_gnt_ovc,
  input  logic [NUM_VC-1:0]    sa_gnt,
  output logic [NUM_VC-1:0]    va_req,
  output logic [PW*NUM_VC-1:0] va_port,
  output logic [NUM_VC-1:0]    sa_req,
  output logic [PW*NUM_VC-1:0] sa_port,
  output logic [OW*NUM_VC-1:0] sa_ovc,
  output logic [NUM_VC-1:0]    deq
);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic          lock_q;
    logic [PW-1:0] port_q;
    logic [OW-1:0] ovc_q;
    logic          set_en;
    logic [PW-1:0] set_port;
    logic [OW-1:0] set_ovc;
    logic          clr_en;

    ivc_vc_req #(.PW(PW), .OW(OW)) req_i (
      .flit_vld   (flit_vld[v]),
      .flit_type  (flit_type[2*v +: 2]),
      .flit_route (flit_route[PW*v +: PW]),
      .lock_q     (lock_q),
      .port_q     (port_q),
      .ovc_q      (ovc_q),
      .va_gnt     (va_gnt[v]),
      .va_gnt_ovc (va_gnt_ovc[OW*v +: OW]),
      .sa_gnt     (sa_gnt[v]),
      .va_req     (va_req[v]),
      .va_port    (va_port[PW*v +: PW]),
      .sa_req     (sa_req[v]),
      .sa_port    (sa_port[PW*v +: PW]),
      .sa_ovc     (sa_ovc[OW*v +: OW]),
      .deq        (deq[v]),
      .set_en     (set_en),
      .set_port   (set_port),
      .set_ovc    (set_ovc),
      .clr_en     (clr_en)
    );

    ivc_vc_state #(.PW(PW), .OW(OW)) st_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (set_en),
      .set_port (set_port),
      .set_ovc  (set_ovc),
      .clr_en   (clr_en),
      .lock_q   (lock_q),
      .port_q   (port_q),
      .ovc_q    (ovc_q)
    );
  end

endmodule

// File: rtl/ivc_ctrl_chk.sv
module ivc_ctrl_chk #(
  parameter int NUM_VC = 4,
  parameter int PW     = 3,
  parameter int OW     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_VC-1:0]    flit_vld,
  input logic [2*NUM_VC-1:0]  flit_type,
  input logic [PW*NUM_VC-1:0] flit_route,
  input logic [NUM_VC-1:0]    va_gnt,
  input logic [OW*NUM_VC-1:0] va_gnt_ovc,
  input logic [NUM_VC-1:0]    sa_gnt,
  input logic [NUM_VC-1:0]    va_req,
  input logic [PW*NUM_VC-1:0] va_port,
  input logic [NUM_VC-1:0]    sa_req,
  input logic [PW*NUM_VC-1:0] sa_port,
  input logic [OW*NUM_VC-1:0] sa_ovc,
  input logic [NUM_VC-1:0]    deq
);

  for (genvar v = 0; v < NUM_VC; v++) begin : g_chk
    logic hd;
    logic tl;
    assign hd = flit_type[2*v];
    assign tl = flit_type[2*v+1];

    // R2
    va_req_head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      va_req[v] |-> (flit_vld[v] && hd && va_port[PW*v +: PW] == flit_route[PW*v +: PW]));

    // R3
    va_win_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (va_req[v] && va_gnt[v]) |->
        (sa_req[v] && sa_ovc[OW*v +: OW] == va_gnt_ovc[OW*v +: OW]
                   && sa_port[PW*v +: PW] == flit_route[PW*v +: PW]));

    // R4
    no_dual_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (va_req[v] && sa_req[v]) |-> va_gnt[v]);

    // R6
    deq_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      deq[v] |-> (sa_gnt[v] && sa_req[v] && flit_vld[v]));

    // R7
    tail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deq[v] && tl) |=> (!sa_req[v] || va_gnt[v]));

    // R12
    lock_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (deq[v] && !tl) |=> !va_req[v]);

    // R5
    locked_port_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sa_req[v] && !va_req[v] && $past(sa_req[v] && !(deq[v] && tl)))
        |-> $stable(sa_port[PW*v +: PW]));
  end

endmodule

bind ivc_ctrl ivc_ctrl_chk #(.NUM_VC(NUM_VC), .PW(PW), .OW(OW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .flit_vld   (flit_vld),
  .flit_type  (flit_type),
  .flit_route (flit_route),
  .va_gnt     (va_gnt),
  .va_gnt_ovc (va_gnt_ovc),
  .sa_gnt     (sa_gnt),
  .va_req     (va_req),
  .va_port    (va_port),
  .sa_req     (sa_req),
  .sa_port    (sa_port),
  .sa_ovc     (sa_ovc),
  .deq        (deq)
);

// File: tb/ivc_ctrl_tb_top.sv
`timescale 1ns/1ps
module ivc_ctrl_tb_top;

  localparam int NV = 4;
  localparam int PW = 3;
  localparam int OW = 2;
  localparam int NROW = 19;

  logic clk;
  logic rst_n;
  logic [NV-1:0]    flit_vld;
  logic [2*NV-1:0]  flit_type;
  logic [PW*NV-1:0] flit_route;
  logic [NV-1:0]    va_gnt;
  logic [OW*NV-1:0] va_gnt_ovc;
  logic [NV-1:0]    sa_gnt;
  logic [NV-1:0]    va_req;
  logic [PW*NV-1:0] va_port;
  logic [NV-1:0]    sa_req;
  logic [PW*NV-1:0] sa_port;
  logic [OW*NV-1:0] sa_ovc;
  logic [NV-1:0]    deq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  ivc_ctrl #(.NUM_VC(NV), .NUM_PORT(5), .NUM_OVC(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .flit_vld(flit_vld), .flit_type(flit_type),
    .flit_route(flit_route), .va_gnt(va_gnt), .va_gnt_ovc(va_gnt_ovc),
    .sa_gnt(sa_gnt), .va_req(va_req), .va_port(va_port), .sa_req(sa_req),
    .sa_port(sa_port), .sa_ovc(sa_ovc), .deq(deq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Row: vld type route vagnt govc sagnt | exp_va exp_sa exp_port exp_ovc exp_deq
  localparam logic [17:0] VEC [NROW] = '{
    18'b0_00_000_0_00_0__0_0_000_00_0, // idle
    18'b1_01_011_0_00_0__1_0_011_00_0, // head waits for VC
    18'b1_01_011_1_10_1__1_1_011_10_1, // VC grant, bypass to switch, leaves
    18'b1_00_101_0_00_0__0_1_011_10_0, // body, route ignored, no switch grant
    18'b1_00_101_0_00_1__0_1_011_10_1, // body leaves
    18'b1_10_000_1_01_1__0_1_011_10_1, // tail, stray VC grant
    18'b1_01_001_1_11_0__1_1_001_11_0, // next head, no idle cycle
    18'b1_01_001_0_00_1__0_1_001_11_1, // head leaves on lock
    18'b1_10_000_0_00_1__0_1_001_11_1, // tail leaves
    18'b1_11_100_1_01_1__1_1_100_01_1, // single-flit packet
    18'b1_00_010_0_00_1__0_0_000_00_0, // body while unlocked
    18'b1_10_010_1_10_1__0_0_000_00_0, // tail while unlocked
    18'b0_00_000_1_01_0__0_0_000_00_0, // grant with nothing
    18'b1_01_010_0_00_0__1_0_010_00_0, // head still sees unlocked VC
    18'b0_01_010_1_01_0__0_0_000_00_0, // invalid head, grant ignored
    18'b1_01_010_1_00_0__1_1_010_00_0, // grant, switch refused
    18'b0_00_000_0_00_0__0_0_000_00_0, // locked, empty buffer
    18'b1_10_111_0_00_1__0_1_010_00_1, // tail on stored port
    18'b1_01_000_0_00_0__1_0_000_00_0  // next head
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_vc(input int v, input logic vld, input logic [1:0] ty,
                          input logic [PW-1:0] rt, input logic vg,
                          input logic [OW-1:0] go, input logic sg);
    flit_vld[v]           = vld;
    flit_type[2*v +: 2]   = ty;
    flit_route[PW*v +: PW] = rt;
    va_gnt[v]             = vg;
    va_gnt_ovc[OW*v +: OW] = go;
    sa_gnt[v]             = sg;
  endtask

  task automatic clear_in();
    flit_vld = '0; flit_type = '0; flit_route = '0;
    va_gnt = '0; va_gnt_ovc = '0; sa_gnt = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    clear_in();
    // R1: while reset is held, a head is asked to allocate, a body is not
    repeat (2) @(posedge clk);
    @(negedge clk);
    drive_vc(0, 1'b1, 2'b00, 3'd1, 1'b0, 2'd0, 1'b1);
    #1;
    chk("R1 body in reset sa_req", int'(sa_req[0]), 0);
    chk("R1 body in reset deq", int'(deq[0]), 0);
    drive_vc(0, 1'b1, 2'b01, 3'd2, 1'b0, 2'd0, 1'b0);
    #1;
    chk("R1 head in reset va_req", int'(va_req[0]), 1);
    clear_in();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 idle va_req", int'(va_req), 0);
    chk("R1 idle sa_req", int'(sa_req), 0);
    chk("R1 idle deq", int'(deq), 0);

    // Table walk on VC 0
    for (int i = 0; i < NROW; i++) begin
      logic [17:0] r;
      r = VEC[i];
      @(negedge clk);
      clear_in();
      drive_vc(0, r[17], r[16:15], r[14:12], r[11], r[10:9], r[8]);
      #1;
      chk("R2 va_req", int'(va_req[0]), int'(r[7]));
      chk("R4 sa_req", int'(sa_req[0]), int'(r[6]));
      chk("R6 deq", int'(deq[0]), int'(r[0]));
      if (r[7]) chk("R2 va_port", int'(va_port[PW-1:0]), int'(r[5:3]));
      if (r[6]) begin
        chk("R5 sa_port", int'(sa_port[PW-1:0]), int'(r[5:3]));
        chk("R3 sa_ovc", int'(sa_ovc[OW-1:0]), int'(r[2:1]));
      end
      chk("R11 other VCs quiet", int'({va_req[NV-1:1], sa_req[NV-1:1], deq[NV-1:1]}), 0);
    end

    // R7: tail leaves, head requests allocation in the next cycle
    @(negedge clk); clear_in();
    drive_vc(2, 1'b1, 2'b01, 3'd3, 1'b1, 2'd1, 1'b1);
    @(negedge clk); clear_in();
    drive_vc(2, 1'b1, 2'b10, 3'd0, 1'b0, 2'd0, 1'b1);
    #1; chk("R7 tail deq", int'(deq[2]), 1);
    @(negedge clk); clear_in();
    drive_vc(2, 1'b1, 2'b01, 3'd4, 1'b0, 2'd0, 1'b0);
    #1;
    chk("R7 head va_req after tail", int'(va_req[2]), 1);
    chk("R7 head va_port", int'(va_port[PW*2 +: PW]), 4);
    chk("R7 head no sa_req", int'(sa_req[2]), 0);

    // R8: single-flit packet on VC 3, then a body sees no lock
    @(negedge clk); clear_in();
    drive_vc(3, 1'b1, 2'b11, 3'd2, 1'b1, 2'd3, 1'b1);
    #1; chk("R8 solo deq", int'(deq[3]), 1);
    @(negedge clk); clear_in();
    drive_vc(3, 1'b1, 2'b00, 3'd2, 1'b0, 2'd0, 1'b1);
    #1; chk("R8 lock dropped", int'(sa_req[3]), 0);

    // R10: repeated grants without requests leave VC 1 unlocked
    @(negedge clk); clear_in();
    drive_vc(1, 1'b1, 2'b00, 3'd1, 1'b1, 2'd2, 1'b0);
    @(negedge clk); clear_in();
    drive_vc(1, 1'b1, 2'b10, 3'd1, 1'b0, 2'd0, 1'b1);
    #1;
    chk("R10 no lock from stray grant", int'(sa_req[1]), 0);
    chk("R9 tail unlocked no deq", int'(deq[1]), 0);

    // R12 + R11: VC 1 holds a lock across a head dequeue while VC 2 waits
    @(negedge clk); clear_in();
    drive_vc(1, 1'b1, 2'b01, 3'd4, 1'b1, 2'd3, 1'b1);
    drive_vc(2, 1'b1, 2'b01, 3'd1, 1'b0, 2'd0, 1'b0);
    @(negedge clk); clear_in();
    drive_vc(1, 1'b1, 2'b00, 3'd0, 1'b0, 2'd0, 1'b0);
    drive_vc(2, 1'b1, 2'b01, 3'd1, 1'b0, 2'd0, 1'b0);
    #1;
    chk("R12 body no va_req", int'(va_req[1]), 0);
    chk("R12 body sa_req", int'(sa_req[1]), 1);
    chk("R12 body sa_port", int'(sa_port[PW*1 +: PW]), 4);
    chk("R12 body sa_ovc", int'(sa_ovc[OW*1 +: OW]), 3);
    chk("R11 VC2 still allocating", int'(va_req[2]), 1);
    chk("R11 VC2 no sa_req", int'(sa_req[2]), 0);

    // R1: reset in mid-packet drops the lock
    @(negedge clk); clear_in();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive_vc(1, 1'b1, 2'b00, 3'd0, 1'b0, 2'd0, 1'b1);
    #1;
    chk("R1 lock cleared by reset", int'(sa_req[1]), 0);
    drive_vc(1, 1'b1, 2'b01, 3'd3, 1'b0, 2'd0, 1'b0);
    #1;
    chk("R1 head allocates after reset", int'(va_req[1]), 1);

    @(negedge clk); clear_in();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule